// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block sits between an internal request/acknowledge bus and an external asynchronous SRAM or ROM port. It accepts one 32-bit word read or write at a time and turns it into a timed external cycle with three phases:

- **Setup:** chip enable is low, the address is valid and no strobe is active.
- **Strobe:** the read strobe or the write strobe is active.
- **Hold:** the strobe is released while the address and chip enable are kept.

The length of each phase comes from a programmable count. Reads and writes each have their own set of counts. Every count is in cycles of the block's clock.

A request that follows an acknowledge directly continues the current run. Chip enable stays low, and the new access may use the short minimum setup. An access that opens a run always gets at least two setup cycles.

A 16-bit ROM option serves each word read with two halfword fetches from one 4-byte-aligned word. The low halfword is fetched first. The two halfwords are packed into a single 32-bit result.

Top module: `async_strobe_ctrl`

## Requirements
- R1: Setup length is max(setup field, 1) cycles for an access inside a run. During setup, `mem_ce_n` is 0, the address is valid and both strobes are 1. The address does not change while a strobe is active.
- R2: The strobe lasts max(strobe field, 1) cycles. `mem_rd_n` goes low for reads and `mem_wr_n` for writes. The two strobes are never low together, and neither is low while `mem_ce_n` is 1.
- R3: Hold lasts exactly the hold field, and 0 is allowed. It is followed by the acknowledge cycle, in which `mem_ce_n` is 0 and both strobes are 1.
- R4: Reads take setup, strobe and hold from the read fields. Writes take them from the write fields.
- R5: An access that starts while `mem_ce_n` is high gets max(setup field, 2) setup cycles.
- R6: The run continues in these cases:
  - `mem_ce_n` stays 0 during the cycle after the acknowledge.
  - If `req_valid` is 1 in that cycle, the next access starts with the R1 setup.
  - Otherwise `mem_ce_n` returns to 1.
- R7: Read data is sampled from `mem_din` on the last strobe cycle. It is presented on `req_rdata` during the acknowledge cycle.
- R8: For a write, `mem_dout` carries the write data and `mem_dout_en` is 1 from the first setup cycle to the last hold cycle. `mem_dout_en` is 0 throughout a read.
- R9: `req_ack` is a one-cycle pulse, given once per request. It is 0 out of reset.
- R10: With `rom16_en` set, a read makes two fetches. The first goes to address {byte_addr[AW-1:2], 0} and the second to {byte_addr[AW-1:2], 1}. The second fetch uses the R1 setup, and only one acknowledge is given, after the second hold.
- R11: In ROM mode, the halfword at offset +2 (second fetch, `mem_din[15:0]`) goes to `req_rdata[31:16]`. The halfword at offset 0 goes to `req_rdata[15:0]`.
- R12: Word accesses, including writes while `rom16_en` is set, drive {0, byte_addr[AW-1:2]}. Byte address bits 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request pending, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with `req_ack` |
| rom16_en | input | 1 | 16-bit ROM mode for reads |
| rd_setup | input | 4 | Read setup count |
| rd_strobe | input | 6 | Read strobe count |
| rd_hold | input | 2 | Read hold count |
| wr_setup | input | 4 | Write setup count |
| wr_strobe | input | 6 | Write strobe count |
| wr_hold | input | 2 | Write hold count |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW-1 | External address (word, or halfword in ROM mode) |
| mem_dout | output | 32 | Data to memory |
| mem_dout_en | output | 1 | Output enable for `mem_dout` |
| mem_din | input | 32 | Data from memory |

## Verification
The hardest case to reach is the boundary between accesses inside a run. There the setup minimum must fall from two cycles to one, and chip enable must not rise. This happens both for a request issued on the cycle right after an acknowledge and for the hidden second fetch of a ROM read. The stimulus chains requests with no idle cycle between them. It mixes read and write directions and uses zero setup, zero strobe and zero hold fields, so that every clamp shows up as an exact phase length. The monitor measures each phase from the external pins and compares it with the length predicted from the programmed fields.

// File: rtl/asc_pkg.sv
// Shared types for the asynchronous memory cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package asc_pkg;

    // Phase of the external cycle; IDLE is the only phase with chip enable high.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_ACK    = 3'd4,
        PH_GAP    = 3'd5
    } phase_e;

endpackage

// File: rtl/asc_timing.sv
// Selects the read or write timing fields for the current access and applies
// the minimum clamps: setup >= 1 (>= 2 when the access opens a run),
// strobe >= 1, hold unchanged (0 legal).
// Assumes: SW >= 2 so that the value 2 fits in the setup field.
module asc_timing #(
    parameter int SW = 4,
    parameter int TW = 6,
    parameter int HW = 2
) (
    input  logic          is_write,
    input  logic          lead,
    input  logic [SW-1:0] rd_setup,
    input  logic [TW-1:0] rd_strobe,
    input  logic [HW-1:0] rd_hold,
    input  logic [SW-1:0] wr_setup,
    input  logic [TW-1:0] wr_strobe,
    input  logic [HW-1:0] wr_hold,
    output logic [SW-1:0] setup_len,
    output logic [TW-1:0] strobe_len,
    output logic [HW-1:0] hold_len
);

    localparam logic [SW-1:0] SETUP_MIN_RUN  = SW'(1);
    localparam logic [SW-1:0] SETUP_MIN_LEAD = SW'(2);
    localparam logic [TW-1:0] STROBE_MIN     = TW'(1);

    logic [SW-1:0] raw_setup;
    logic [TW-1:0] raw_strobe;
    logic [SW-1:0] setup_floor;

    // Pick the field set that matches the direction of the access.
    always_comb begin
        raw_setup  = is_write ? wr_setup  : rd_setup;
        raw_strobe = is_write ? wr_strobe : rd_strobe;
        hold_len   = is_write ? wr_hold   : rd_hold;
    end

    // Apply the minimum setup and strobe lengths.
    always_comb begin
        setup_floor = lead ? SETUP_MIN_LEAD : SETUP_MIN_RUN;
        setup_len   = (raw_setup < setup_floor) ? setup_floor : raw_setup;
        strobe_len  = (raw_strobe == '0) ? STROBE_MIN : raw_strobe;
    end

endmodule

// File: rtl/asc_sequencer.sv
// Phase sequencer: walks setup, strobe and hold with one down-counter,
// inserts the second halfword fetch of a ROM read, then spends one
// acknowledge cycle and one run-continuation cycle with chip enable low.
// Assumes: timing lengths are already clamped (setup, strobe >= 1).
module asc_sequencer
    import asc_pkg::*;
#(
    parameter int SW = 4,
    parameter int TW = 6,
    parameter int HW = 2,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          rom16_en,
    input  logic [SW-1:0] setup_len,
    input  logic [TW-1:0] strobe_len,
    input  logic [HW-1:0] hold_len,
    output phase_e        phase,
    output logic          op_write,
    output logic          rom_op,
    output logic          half_sel,
    output logic          accept,
    output logic          capture,
    output logic          timing_write,
    output logic          timing_lead
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    phase_e        phase_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          half_d;
    logic          finish;

    // A request is taken only while idle or in the continuation cycle.
    assign accept       = ((phase == PH_IDLE) || (phase == PH_GAP)) && req_valid;
    // Timing follows the incoming request while accepting, else the latched one.
    assign timing_write = accept ? req_write : op_write;
    assign timing_lead  = (phase == PH_IDLE);
    // Read data is sampled on the last strobe cycle.
    assign capture      = (phase == PH_STROBE) && (cnt_q == '0) && !op_write;

    // Next phase, counter and halfword selection.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt_q;
        half_d  = half_sel;
        finish  = 1'b0;
        case (phase)
            PH_IDLE, PH_GAP: begin
                if (req_valid) begin
                    phase_d = PH_SETUP;
                    cnt_d   = CW'(setup_len) - CNT_ONE;
                    half_d  = 1'b0;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    phase_d = PH_STROBE;
                    cnt_d   = CW'(strobe_len) - CNT_ONE;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    if (hold_len != '0) begin
                        phase_d = PH_HOLD;
                        cnt_d   = CW'(hold_len) - CNT_ONE;
                    end else begin
                        finish = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    finish = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            PH_ACK:  phase_d = PH_GAP;
            default: phase_d = PH_IDLE;
        endcase
        if (finish) begin
            if (rom_op && !half_sel) begin
                half_d  = 1'b1;
                phase_d = PH_SETUP;
                cnt_d   = CW'(setup_len) - CNT_ONE;
            end else begin
                phase_d = PH_ACK;
            end
        end
    end

    // Phase state, counter and halfword flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt_q    <= '0;
            half_sel <= 1'b0;
        end else begin
            phase    <= phase_d;
            cnt_q    <= cnt_d;
            half_sel <= half_d;
        end
    end

    // Latch the direction and ROM packing of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            rom_op   <= 1'b0;
        end else if (accept) begin
            op_write <= req_write;
            rom_op   <= rom16_en && !req_write;
        end
    end

endmodule

// File: rtl/asc_datapath.sv
// Address and data path: holds the word index and write data of the current
// request, forms the external address (word, or halfword in ROM mode) and
// collects read data into two halfword lanes.
// Assumes: DW is even; the word index is byte_addr[AW-1:2].
module asc_datapath #(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int EAW = AW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic [AW-3:0]  word_idx,
    input  logic [DW-1:0]  req_wdata,
    input  logic           rom_op,
    input  logic           half_sel,
    input  logic           capture,
    input  logic [DW-1:0]  mem_din,
    output logic [EAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_dout,
    output logic [DW-1:0]  req_rdata
);

    localparam int HALF = DW / 2;

    logic [AW-3:0] idx_q;
    logic [DW-1:0] wdata_q;

    // Hold address and write data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            idx_q   <= word_idx;
            wdata_q <= req_wdata;
        end
    end

    // Word index alone, or word index shifted up with the halfword select.
    assign mem_addr = rom_op ? {idx_q, half_sel} : {1'b0, idx_q};
    assign mem_dout = wdata_q;

    // One register per halfword lane; ROM mode fills each lane from the low bus half.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HALF-1:0] lane_q;
        logic            lane_en;

        assign lane_en = capture && (!rom_op || (half_sel == 1'(g)));

        // Capture this lane on the last strobe cycle of its fetch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (lane_en) begin
                lane_q <= rom_op ? mem_din[HALF-1:0] : mem_din[g*HALF +: HALF];
            end
        end

        assign req_rdata[g*HALF +: HALF] = lane_q;
    end

endmodule

// File: rtl/async_strobe_ctrl.sv
// Top of the asynchronous memory cycle sequencer. Converts word requests into
// setup/strobe/hold shaped cycles on an asynchronous SRAM/ROM port.
// Assumes: timing fields and rom16_en change only while no request is in
// flight; the requester holds a request until req_ack.
module async_strobe_ctrl
    import asc_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int SW  = 4,
    parameter int TW  = 6,
    parameter int HW  = 2,
    localparam int EAW = AW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ack,
    output logic [DW-1:0]  req_rdata,
    input  logic           rom16_en,
    input  logic [SW-1:0]  rd_setup,
    input  logic [TW-1:0]  rd_strobe,
    input  logic [HW-1:0]  rd_hold,
    input  logic [SW-1:0]  wr_setup,
    input  logic [TW-1:0]  wr_strobe,
    input  logic [HW-1:0]  wr_hold,
    output logic           mem_ce_n,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic [EAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_dout,
    output logic           mem_dout_en,
    input  logic [DW-1:0]  mem_din
);

    localparam int CW = (TW > SW) ? ((TW > HW) ? TW : HW) : ((SW > HW) ? SW : HW);

    phase_e        phase;
    logic          op_write;
    logic          rom_op;
    logic          half_sel;
    logic          accept;
    logic          capture;
    logic          timing_write;
    logic          timing_lead;
    logic [SW-1:0] setup_len;
    logic [TW-1:0] strobe_len;
    logic [HW-1:0] hold_len;
    logic          unused_byte_lanes;

    // Byte offset within a word never reaches the port.
    assign unused_byte_lanes = ^req_addr[1:0];

    asc_timing #(.SW(SW), .TW(TW), .HW(HW)) u_timing (
        .is_write   (timing_write),
        .lead       (timing_lead),
        .rd_setup   (rd_setup),
        .rd_strobe  (rd_strobe),
        .rd_hold    (rd_hold),
        .wr_setup   (wr_setup),
        .wr_strobe  (wr_strobe),
        .wr_hold    (wr_hold),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len)
    );

    asc_sequencer #(.SW(SW), .TW(TW), .HW(HW), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .rom16_en     (rom16_en),
        .setup_len    (setup_len),
        .strobe_len   (strobe_len),
        .hold_len     (hold_len),
        .phase        (phase),
        .op_write     (op_write),
        .rom_op       (rom_op),
        .half_sel     (half_sel),
        .accept       (accept),
        .capture      (capture),
        .timing_write (timing_write),
        .timing_lead  (timing_lead)
    );

    asc_datapath #(.AW(AW), .DW(DW), .EAW(EAW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .word_idx  (req_addr[AW-1:2]),
        .req_wdata (req_wdata),
        .rom_op    (rom_op),
        .half_sel  (half_sel),
        .capture   (capture),
        .mem_din   (mem_din),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .req_rdata (req_rdata)
    );

    // Pin decode from the registered phase.
    always_comb begin
        mem_ce_n    = (phase == PH_IDLE);
        mem_rd_n    = !((phase == PH_STROBE) && !op_write);
        mem_wr_n    = !((phase == PH_STROBE) && op_write);
        mem_dout_en = op_write && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                                   (phase == PH_HOLD));
        req_ack     = (phase == PH_ACK);
    end

endmodule

// File: rtl/asc_checker.sv
// Protocol checker for async_strobe_ctrl, attached by bind below.
// Assumes: observed only at the top-level pins.
module asc_checker #(
    parameter int EAW = 23
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_ce_n,
    input logic           mem_rd_n,
    input logic           mem_wr_n,
    input logic           mem_dout_en,
    input logic [EAW-1:0] mem_addr,
    input logic           req_ack
);

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    assert_strobe_in_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_ce_n);

    assert_addr_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_rd_n || !mem_wr_n) && $past(!mem_rd_n || !mem_wr_n)) |-> $stable(mem_addr));

    assert_ack_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!mem_ce_n && mem_rd_n && mem_wr_n));

    assert_lead_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (mem_rd_n && mem_wr_n));

    assert_lead_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |=> (mem_rd_n && mem_wr_n));

    assert_oe_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dout_en);

    assert_oe_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_dout_en);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

endmodule

bind async_strobe_ctrl asc_checker #(.EAW(EAW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_ce_n    (mem_ce_n),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_dout_en (mem_dout_en),
    .mem_addr    (mem_addr),
    .req_ack     (req_ack)
);

// File: tb/sim_async_strobe_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected external cycle per fetch,
// the monitor measures phases at the pins and compares.
module sim_async_strobe_ctrl;

    localparam int AW = 24, DW = 32, SW = 4, TW = 6, HW = 2, EAW = AW - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ack;
    logic [DW-1:0]  req_rdata;
    logic           rom16_en = 1'b0;
    logic [SW-1:0]  rd_setup = '0, wr_setup = '0;
    logic [TW-1:0]  rd_strobe = '0, wr_strobe = '0;
    logic [HW-1:0]  rd_hold = '0, wr_hold = '0;
    logic           mem_ce_n, mem_rd_n, mem_wr_n, mem_dout_en;
    logic [EAW-1:0] mem_addr;
    logic [DW-1:0]  mem_dout, mem_din;

    typedef struct {
        bit             wr;
        bit             lead;
        logic [EAW-1:0] addr;
        logic [DW-1:0]  wd;
        int             su, st, ho;
    } cyc_t;

    cyc_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    async_strobe_ctrl #(.AW(AW), .DW(DW), .SW(SW), .TW(TW), .HW(HW)) u0 (.*);

    function automatic logic [DW-1:0] mem_val(input logic [EAW-1:0] a);
        return {a[15:0] ^ 16'hA5C3, a[15:0] ^ 16'h3C00};
    endfunction

    // Memory model: returns data only while the read strobe is active.
    assign mem_din = !mem_rd_n ? mem_val(mem_addr) : 32'hDEAD_BEEF;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Driver: predict external cycles, issue the request, check read data at ack.
    task automatic xfer(input bit wr, input logic [AW-1:0] ba,
                        input logic [DW-1:0] wd, input bit lead);
        cyc_t c;
        int   s, t, h, waited;
        logic [DW-1:0] exp_rd;
        s = wr ? int'(wr_setup)  : int'(rd_setup);
        t = wr ? int'(wr_strobe) : int'(rd_strobe);
        h = wr ? int'(wr_hold)   : int'(rd_hold);
        c.wr = wr; c.wd = wd; c.ho = h; c.lead = lead;
        c.st = (t == 0) ? 1 : t;
        c.su = (s < (lead ? 2 : 1)) ? (lead ? 2 : 1) : s;
        if (rom16_en && !wr) begin
            c.addr = {ba[AW-1:2], 1'b0};
            exp_q.push_back(c);
            exp_rd[15:0] = mem_val(c.addr)[15:0];
            c.lead = 1'b0;
            c.su   = (s < 1) ? 1 : s;
            c.addr = {ba[AW-1:2], 1'b1};
            exp_q.push_back(c);
            exp_rd[31:16] = mem_val(c.addr)[15:0];
        end else begin
            c.addr = {1'b0, ba[AW-1:2]};
            exp_q.push_back(c);
            exp_rd = mem_val(c.addr);
        end
        req_valid = 1'b1; req_write = wr; req_addr = ba; req_wdata = wd;
        waited = 0;
        forever begin
            @(negedge clk);
            if (req_ack || waited > 2000) break;
            waited++;
        end
        if (!wr) chk(rom16_en ? "R11" : "R7", "read data", req_rdata, exp_rd);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic set_rd(input int s, input int t, input int h);
        rd_setup = SW'(s); rd_strobe = TW'(t); rd_hold = HW'(h);
    endtask
    task automatic set_wr(input int s, input int t, input int h);
        wr_setup = SW'(s); wr_strobe = TW'(t); wr_hold = HW'(h);
    endtask

    // Monitor: measure setup/strobe/hold at the pins and compare with the queue.
    int             m_ph = 0, su = 0, st = 0, ho = 0;
    logic [EAW-1:0] prev_addr = '0;
    logic           prev_ce_n = 1'b1, prev_ack = 1'b0;
    cyc_t           cur;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit sa = !mem_rd_n || !mem_wr_n;
            if (prev_ack) chk("R6", "ce low after ack", mem_ce_n, 1'b0);
            if (m_ph == 2 && !sa) begin m_ph = 3; ho = 0; end
            if (m_ph == 3) begin
                if (req_ack || mem_ce_n || mem_addr != prev_addr) begin
                    chk(cur.lead ? "R5" : "R1", "setup cycles", su, cur.su);
                    chk("R2", "strobe cycles", st, cur.st);
                    chk("R3", "hold cycles", ho, cur.ho);
                    m_ph = 0;
                end else begin
                    ho++;
                end
            end
            if (!mem_ce_n && !sa && (prev_ce_n || mem_addr != prev_addr)) begin
                m_ph = 1; su = 1;
                if (exp_q.size() > 0)
                    chk("R8", "output enable in setup", mem_dout_en, exp_q[0].wr);
            end else if (m_ph == 1 && !sa) begin
                su++;
            end
            if (sa) begin
                if (m_ph == 1) begin
                    m_ph = 2; st = 1;
                    if (exp_q.size() == 0) begin
                        chk("R9", "unexpected strobe", 1, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        chk("R4", "strobe direction", !mem_wr_n, cur.wr);
                        chk(rom16_en ? "R10" : "R12", "address", mem_addr, cur.addr);
                        if (cur.wr) chk("R8", "write data", mem_dout, cur.wd);
                    end
                end else if (m_ph == 2) begin
                    st++;
                end
            end
            prev_addr = mem_addr;
            prev_ce_n = mem_ce_n;
            prev_ack  = req_ack;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        finish_up();
    end

    task automatic idle_check(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        chk("R6", "ce high when idle", mem_ce_n, 1'b1);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset ack", req_ack, 1'b0);
        chk("R2", "reset strobes", {mem_ce_n, mem_rd_n, mem_wr_n}, 3'b111);
        chk("R8", "reset output enable", mem_dout_en, 1'b0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        // Zero fields: clamps and lead setup of 2, hold of 0.
        set_rd(0, 0, 0); set_wr(3, 5, 2);
        xfer(0, 24'h000104, '0, 1);
        idle_check(2);
        xfer(1, 24'h000208, 32'h1234_5678, 1);
        idle_check(2);
        set_wr(0, 0, 0);
        xfer(1, 24'h00020C, 32'hCAFE_F00D, 1);
        idle_check(2);

        // Back-to-back run mixing directions.
        set_rd(1, 2, 1); set_wr(0, 3, 3);
        xfer(0, 24'h000300, '0, 1);
        xfer(1, 24'h000304, 32'hA1B2_C3D4, 0);
        xfer(0, 24'h000308, '0, 0);
        xfer(0, 24'h00030C, '0, 0);
        idle_check(3);

        // Largest fields, then a chained write.
        set_rd(15, 63, 3); set_wr(2, 1, 1);
        xfer(0, 24'h000400, '0, 1);
        xfer(1, 24'h000404, 32'h0F0F_F0F0, 0);
        idle_check(2);

        // Byte offset bits ignored in word mode.
        set_rd(3, 2, 2);
        xfer(0, 24'h00050B, '0, 1);
        xfer(1, 24'h000513, 32'h5555_AAAA, 0);
        idle_check(2);

        // 16-bit ROM mode: two fetches, packing, chained reads and a word write.
        rom16_en = 1'b1;
        set_rd(0, 2, 0); set_wr(1, 1, 0);
        xfer(0, 24'h000600, '0, 1);
        xfer(0, 24'h000606, '0, 0);
        xfer(1, 24'h000710, 32'h7777_8888, 0);
        xfer(0, 24'h000800, '0, 0);
        idle_check(2);
        set_rd(4, 1, 2);
        xfer(0, 24'h000904, '0, 1);
        idle_check(2);
        rom16_en = 1'b0;

        repeat (4) @(posedge clk);
        chk("R9", "all predicted cycles seen", exp_q.size(), 0);
        finish_up();
    end

endmodule